// File: doc/BRIEF.md
# Flash Block-Lock and Power-Down Controller

This controller sits between a decoded command path and a 512 KB flash array cut into 32 equal erase sections of 16 KB. It keeps one stored lock bit per section and a separate "locks valid" flag. It decides whether a program or single-section erase may start. It runs an erase over every unlocked section, and it times each operation with a cycle counter. While an operation runs it presents the target section, word address and byte lanes to the array.

A single active-low reset/power-down pin aborts any running operation. It returns the write state machine to its recovery state, clears the status byte and drops the "locks valid" flag. The stored lock bits are kept, and only a separate power-on reset restores them. Until a protect-confirm command arrives, every section is treated as locked. The erase-unlocked command is the one exception: it may run before confirmation, it still obeys the stored bits, and when it finishes the locks become valid. Busy is shown as an active-low level plus a drive-enable, so that several devices can share one wired ready line.

The write state machine has six states. RECOVER is entered on reset and left for IDLE when the recovery count expires. From IDLE, an accepted program goes to PROGRAM, an accepted erase goes to ERASE, and erase-unlocked goes to SWEEP_SCAN. PROGRAM and ERASE return to IDLE when their count expires. SWEEP_SCAN moves to SWEEP_ERASE when the section under the cursor is unlocked. Otherwise it steps the cursor, or goes to IDLE after the last section. SWEEP_ERASE returns to SWEEP_SCAN when its count expires, or to IDLE after the last section.

Top module: `flash_lock_ctrl`

## Requirements
- R1: The target section of a program or erase is `cmd_addr[18:14]`. While the operation runs, `op_block` shows that section and `op_waddr` shows `cmd_addr[18:1]`, both held steady.
- R2: After any reset, and before a protect-confirm (opcode 4), a program (opcode 1) or section erase (opcode 2) to any section is refused. The machine stays ready, and status bit 4 (program refused) or bit 5 (erase refused) is set.
- R3: Once a protect-confirm is accepted, status bit 0 reads 1. A program or erase then starts only if the stored lock bit of its section is clear, and is refused as in R2 otherwise.
- R4: Erase-unlocked (opcode 3) is accepted before confirmation. It visits sections 0 to 31 in ascending order and erases only those whose stored bit is clear, with `op_lanes` = 11. It is busy for 32 + ERASE_CYCLES × (number of unlocked sections) cycles. Afterwards status bit 0 is 1 and programs to unlocked sections start.
- R5: An accepted program is busy for exactly PROG_CYCLES cycles and an accepted erase for exactly ERASE_CYCLES cycles. Status bit 7 (ready) returns to 1 at completion.
- R6: While `rst_pwd_n` is low, the status byte is 0, `op_active` is 0 and any running operation is abandoned at once. Afterwards status bit 0 is 0 again.
- R7: After `rst_pwd_n` rises, ready stays low for exactly RECOV_CYCLES clock cycles, then status reads 0x80.
- R8: With `byte_mode` = 1, `cmd_addr[0]` = 0 gives `op_lanes` = 01 and `cmd_addr[0]` = 1 gives 10. With `byte_mode` = 0, `op_lanes` is 11 whatever `cmd_addr[0]` is.
- R9: While not ready, `ry_by_oe` = 1 and `ry_by_n` = 0. While ready, `ry_by_oe` = 0 and `ry_by_n` = 1.
- R10: Every command that arrives while not ready is ignored: it changes neither the lock bits, nor the error bits, nor the operation in progress.
- R11: Lock-section (opcode 5) sets one stored bit and unlock-all (opcode 6) clears all stored bits. Stored bits survive `rst_pwd_n`, and only `por_n` low restores them to LOCK_INIT, without touching status bit 0.
- R12: The error bits 4 and 5 stay set across later successful operations. Only a clear-status (opcode 7) accepted while ready clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; restores stored lock bits |
| rst_pwd_n | input | 1 | Reset/power-down pin, active low, asynchronous |
| cmd_valid | input | 1 | Decoded command strobe, one cycle |
| cmd_op | input | 3 | Opcode: 0 none, 1 program, 2 section erase, 3 erase-unlocked, 4 protect-confirm, 5 lock section, 6 unlock all, 7 clear status |
| cmd_addr | input | 19 | Byte address; bit 0 is the byte-select bit |
| byte_mode | input | 1 | 1 = byte-wide access, 0 = word-wide |
| status | output | 8 | Bit 7 ready, bit 5 erase refused, bit 4 program refused, bit 0 locks valid, others 0 |
| ry_by_n | output | 1 | Ready/busy level, low while busy |
| ry_by_oe | output | 1 | Drive enable for the shared ready line |
| op_active | output | 1 | Array operation in progress |
| op_kind | output | 2 | 1 program, 2 erase, 0 none |
| op_block | output | 5 | Section under operation |
| op_waddr | output | 18 | Word address of the operation |
| op_lanes | output | 2 | Byte lanes enabled for the operation |

## Verification
The hardest states to reach are those that depend on lock history across resets. One is a section whose stored bit is clear but which still refuses programs, because the locks-valid flag was dropped by a power-down pulse. Another is an erase-unlocked sweep that has to skip a known, scattered set of locked sections. The stimulus locks every third section before any confirmation and runs the sweep at that point. It pulses the power-down pin mid-operation and again between sweeps. It then walks all 32 sections after confirmation, so that both the stored-bit path and the invalid-flag path are reached from the ports.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

    typedef enum logic [2:0] {
        OP_NOP             = 3'd0,
        OP_PROGRAM         = 3'd1,
        OP_BLK_ERASE       = 3'd2,
        OP_ERASE_UNLOCKED  = 3'd3,
        OP_PROTECT_CONFIRM = 3'd4,
        OP_LOCK_BLOCK      = 3'd5,
        OP_UNLOCK_ALL      = 3'd6,
        OP_CLEAR_STATUS    = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        ST_RECOVER,
        ST_IDLE,
        ST_PROGRAM,
        ST_ERASE,
        ST_SWEEP_SCAN,
        ST_SWEEP_ERASE
    } wsm_e;

    typedef enum logic [1:0] {
        KIND_NONE    = 2'd0,
        KIND_PROGRAM = 2'd1,
        KIND_ERASE   = 2'd2
    } kind_e;

    localparam int STS_W          = 8;
    localparam int STS_READY      = 7;
    localparam int STS_ERS_ERR    = 5;
    localparam int STS_PRG_ERR    = 4;
    localparam int STS_LOCK_VALID = 0;
    localparam int LANES          = 2;

endpackage

// File: rtl/flash_addr_decode.sv
module flash_addr_decode #(
    parameter int ADDR_W = 19,
    parameter int BLK_W  = 5,
    parameter int LANES  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_mode,
    output logic [BLK_W-1:0]  blk,
    output logic [ADDR_W-2:0] word_addr,
    output logic [LANES-1:0]  lanes
);

    // The section index is the top field of the byte address.
    assign blk       = addr[ADDR_W-1 -: BLK_W];
    // Word address drops the byte-select bit.
    assign word_addr = addr[ADDR_W-1:1];

    // One enable per byte lane; in word mode all lanes are on.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = !byte_mode || (addr[0] == 1'(g));
    end

endmodule

// File: rtl/flash_lock_store.sv
module flash_lock_store #(
    parameter int                    NUM_BLOCKS = 32,
    parameter int                    BLK_W      = 5,
    parameter logic [NUM_BLOCKS-1:0] LOCK_INIT  = '0
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  rst_pwd_n,
    input  logic                  set_en,
    input  logic [BLK_W-1:0]      set_idx,
    input  logic                  clr_all,
    input  logic                  valid_set,
    output logic [NUM_BLOCKS-1:0] lock_bits,
    output logic                  lock_valid,
    output logic [NUM_BLOCKS-1:0] eff_lock
);

    // Stored lock bits: only a power-on reset restores them.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lock_bits <= LOCK_INIT;
        end else if (clr_all) begin
            lock_bits <= '0;
        end else if (set_en) begin
            lock_bits[set_idx] <= 1'b1;
        end
    end

    // Validity flag: dropped by the reset/power-down pin.
    always_ff @(posedge clk or negedge rst_pwd_n) begin
        if (!rst_pwd_n) begin
            lock_valid <= 1'b0;
        end else if (valid_set) begin
            lock_valid <= 1'b1;
        end
    end

    // Effective lock: everything is locked until the flag is valid.
    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_eff
        assign eff_lock[g] = lock_bits[g] | ~lock_valid;
    end

endmodule

// File: rtl/flash_cycle_timer.sv
module flash_cycle_timer #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Down counter that rests at zero; reset preloads the recovery span.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= RST_VAL;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
    import flash_lock_pkg::*;
#(
    parameter int NUM_BLOCKS   = 32,
    parameter int BLK_W        = 5,
    parameter int ADDR_W       = 19,
    parameter int TMR_W        = 8,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 32
) (
    input  logic                  clk,
    input  logic                  rst_pwd_n,
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd_op,
    input  logic [BLK_W-1:0]      dec_blk,
    input  logic [ADDR_W-2:0]     dec_waddr,
    input  logic [LANES-1:0]      dec_lanes,
    input  logic [NUM_BLOCKS-1:0] eff_lock,
    input  logic [NUM_BLOCKS-1:0] lock_bits,
    input  logic                  tmr_zero,
    output logic                  tmr_load,
    output logic [TMR_W-1:0]      tmr_val,
    output logic                  lock_set,
    output logic                  lock_clr_all,
    output logic                  valid_set,
    output logic                  ready,
    output logic                  op_active,
    output logic [1:0]            op_kind,
    output logic [BLK_W-1:0]      op_block,
    output logic [ADDR_W-2:0]     op_waddr,
    output logic [LANES-1:0]      op_lanes,
    output logic                  prg_err,
    output logic                  ers_err
);

    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
    localparam logic [TMR_W-1:0] PROG_LD  = TMR_W'(PROG_CYCLES - 1);
    localparam logic [TMR_W-1:0] ERASE_LD = TMR_W'(ERASE_CYCLES - 1);
    localparam int               LOW_W    = ADDR_W - 1 - BLK_W;

    wsm_e                state, state_nx;
    logic [BLK_W-1:0]    sweep_idx;
    logic [BLK_W-1:0]    lat_blk;
    logic [ADDR_W-2:0]   lat_waddr;
    logic [LANES-1:0]    lat_lanes;

    logic accept, tgt_locked;
    logic start_prog, start_erase, rej_prog, rej_erase, start_sweep;
    logic sweep_hit, sweep_last, sweep_step, sweep_done;

    // Command qualification
    always_comb begin
        accept      = (state == ST_IDLE) && cmd_valid;
        tgt_locked  = eff_lock[dec_blk];
        start_prog  = accept && (cmd_op == OP_PROGRAM)   && !tgt_locked;
        rej_prog    = accept && (cmd_op == OP_PROGRAM)   &&  tgt_locked;
        start_erase = accept && (cmd_op == OP_BLK_ERASE) && !tgt_locked;
        rej_erase   = accept && (cmd_op == OP_BLK_ERASE) &&  tgt_locked;
        start_sweep = accept && (cmd_op == OP_ERASE_UNLOCKED);
        sweep_hit   = (state == ST_SWEEP_SCAN) && !lock_bits[sweep_idx];
        sweep_last  = (sweep_idx == LAST_BLK);
        sweep_step  = ((state == ST_SWEEP_SCAN) && !sweep_hit && !sweep_last) ||
                      ((state == ST_SWEEP_ERASE) && tmr_zero && !sweep_last);
        sweep_done  = ((state == ST_SWEEP_SCAN) && !sweep_hit && sweep_last) ||
                      ((state == ST_SWEEP_ERASE) && tmr_zero && sweep_last);
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RECOVER: begin
                if (tmr_zero) state_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (start_prog)        state_nx = ST_PROGRAM;
                else if (start_erase)  state_nx = ST_ERASE;
                else if (start_sweep)  state_nx = ST_SWEEP_SCAN;
            end
            ST_PROGRAM, ST_ERASE: begin
                if (tmr_zero) state_nx = ST_IDLE;
            end
            ST_SWEEP_SCAN: begin
                if (sweep_hit)        state_nx = ST_SWEEP_ERASE;
                else if (sweep_last)  state_nx = ST_IDLE;
            end
            ST_SWEEP_ERASE: begin
                if (tmr_zero) state_nx = sweep_last ? ST_IDLE : ST_SWEEP_SCAN;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_pwd_n) begin
        if (!rst_pwd_n) state <= ST_RECOVER;
        else            state <= state_nx;
    end

    // Latched operation data, sweep cursor and sticky error bits
    always_ff @(posedge clk or negedge rst_pwd_n) begin
        if (!rst_pwd_n) begin
            lat_blk   <= '0;
            lat_waddr <= '0;
            lat_lanes <= '0;
            sweep_idx <= '0;
            prg_err   <= 1'b0;
            ers_err   <= 1'b0;
        end else begin
            if (start_prog || start_erase) begin
                lat_blk   <= dec_blk;
                lat_waddr <= dec_waddr;
                lat_lanes <= dec_lanes;
            end
            if (start_sweep)      sweep_idx <= '0;
            else if (sweep_step)  sweep_idx <= sweep_idx + 1'b1;
            if (accept && (cmd_op == OP_CLEAR_STATUS)) begin
                prg_err <= 1'b0;
                ers_err <= 1'b0;
            end else begin
                if (rej_prog)  prg_err <= 1'b1;
                if (rej_erase) ers_err <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        ready        = (state == ST_IDLE);
        tmr_load     = start_prog || start_erase || sweep_hit;
        tmr_val      = start_prog ? PROG_LD : ERASE_LD;
        lock_set     = accept && (cmd_op == OP_LOCK_BLOCK);
        lock_clr_all = accept && (cmd_op == OP_UNLOCK_ALL);
        valid_set    = (accept && (cmd_op == OP_PROTECT_CONFIRM)) || sweep_done;
        op_active    = 1'b0;
        op_kind      = KIND_NONE;
        op_block     = lat_blk;
        op_waddr     = lat_waddr;
        op_lanes     = lat_lanes;
        unique case (state)
            ST_PROGRAM: begin
                op_active = 1'b1;
                op_kind   = KIND_PROGRAM;
            end
            ST_ERASE: begin
                op_active = 1'b1;
                op_kind   = KIND_ERASE;
            end
            ST_SWEEP_ERASE: begin
                op_active = 1'b1;
                op_kind   = KIND_ERASE;
                op_block  = sweep_idx;
                op_waddr  = {sweep_idx, {LOW_W{1'b0}}};
                op_lanes  = '1;
            end
            default: begin
                op_active = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
    import flash_lock_pkg::*;
#(
    parameter int                    ADDR_W       = 19,
    parameter int                    NUM_BLOCKS   = 32,
    parameter int                    PROG_CYCLES  = 8,
    parameter int                    ERASE_CYCLES = 32,
    parameter int                    RECOV_CYCLES = 150,
    parameter logic [NUM_BLOCKS-1:0] LOCK_INIT    = '0
) (
    input  logic                          clk,
    input  logic                          por_n,
    input  logic                          rst_pwd_n,
    input  logic                          cmd_valid,
    input  logic [2:0]                    cmd_op,
    input  logic [ADDR_W-1:0]             cmd_addr,
    input  logic                          byte_mode,
    output logic [7:0]                    status,
    output logic                          ry_by_n,
    output logic                          ry_by_oe,
    output logic                          op_active,
    output logic [1:0]                    op_kind,
    output logic [$clog2(NUM_BLOCKS)-1:0] op_block,
    output logic [ADDR_W-2:0]             op_waddr,
    output logic [1:0]                    op_lanes
);

    localparam int BLK_W   = $clog2(NUM_BLOCKS);
    localparam int MAX_PE  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int MAX_CYC = (MAX_PE > RECOV_CYCLES) ? MAX_PE : RECOV_CYCLES;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam logic [TMR_W-1:0] RECOV_LD = TMR_W'(RECOV_CYCLES - 1);

    logic [BLK_W-1:0]      dec_blk;
    logic [ADDR_W-2:0]     dec_waddr;
    logic [LANES-1:0]      dec_lanes;
    logic [NUM_BLOCKS-1:0] lock_bits, eff_lock;
    logic                  lock_valid;
    logic                  tmr_load, tmr_zero;
    logic [TMR_W-1:0]      tmr_val;
    logic                  lock_set, lock_clr_all, valid_set;
    logic                  ready, prg_err, ers_err;

    flash_addr_decode #(
        .ADDR_W (ADDR_W),
        .BLK_W  (BLK_W),
        .LANES  (LANES)
    ) u_dec (
        .addr      (cmd_addr),
        .byte_mode (byte_mode),
        .blk       (dec_blk),
        .word_addr (dec_waddr),
        .lanes     (dec_lanes)
    );

    flash_lock_store #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W),
        .LOCK_INIT  (LOCK_INIT)
    ) u_locks (
        .clk        (clk),
        .por_n      (por_n),
        .rst_pwd_n  (rst_pwd_n),
        .set_en     (lock_set),
        .set_idx    (dec_blk),
        .clr_all    (lock_clr_all),
        .valid_set  (valid_set),
        .lock_bits  (lock_bits),
        .lock_valid (lock_valid),
        .eff_lock   (eff_lock)
    );

    flash_cycle_timer #(
        .W       (TMR_W),
        .RST_VAL (RECOV_LD)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_pwd_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    flash_wsm #(
        .NUM_BLOCKS   (NUM_BLOCKS),
        .BLK_W        (BLK_W),
        .ADDR_W       (ADDR_W),
        .TMR_W        (TMR_W),
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_wsm (
        .clk          (clk),
        .rst_pwd_n    (rst_pwd_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .dec_blk      (dec_blk),
        .dec_waddr    (dec_waddr),
        .dec_lanes    (dec_lanes),
        .eff_lock     (eff_lock),
        .lock_bits    (lock_bits),
        .tmr_zero     (tmr_zero),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .lock_set     (lock_set),
        .lock_clr_all (lock_clr_all),
        .valid_set    (valid_set),
        .ready        (ready),
        .op_active    (op_active),
        .op_kind      (op_kind),
        .op_block     (op_block),
        .op_waddr     (op_waddr),
        .op_lanes     (op_lanes),
        .prg_err      (prg_err),
        .ers_err      (ers_err)
    );

    always_comb begin
        status                 = '0;
        status[STS_READY]      = ready;
        status[STS_ERS_ERR]    = ers_err;
        status[STS_PRG_ERR]    = prg_err;
        status[STS_LOCK_VALID] = lock_valid;
    end

    // Shared wired line: pull low while busy, release otherwise.
    assign ry_by_oe = ~ready;
    assign ry_by_n  = ready;

endmodule

// File: rtl/flash_lock_chk.sv
module flash_lock_chk
    import flash_lock_pkg::*;
#(
    parameter int BLK_W = 5
) (
    input logic             clk,
    input logic             rst_pwd_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [7:0]       status,
    input logic             ry_by_n,
    input logic             ry_by_oe,
    input logic             op_active,
    input logic [1:0]       op_kind,
    input logic [BLK_W-1:0] op_block
);

    AST_LOCKED_PROG_REJECT: assert property (@(posedge clk) disable iff (!rst_pwd_n)
        cmd_valid && status[STS_READY] && (cmd_op == OP_PROGRAM) && !status[STS_LOCK_VALID]
        |=> status[STS_READY] && status[STS_PRG_ERR]); // R2

    AST_LOCKED_ERASE_REJECT: assert property (@(posedge clk) disable iff (!rst_pwd_n)
        cmd_valid && status[STS_READY] && (cmd_op == OP_BLK_ERASE) && !status[STS_LOCK_VALID]
        |=> status[STS_READY] && status[STS_ERS_ERR]); // R2

    AST_CONFIRM_VALID: assert property (@(posedge clk) disable iff (!rst_pwd_n)
        cmd_valid && status[STS_READY] && (cmd_op == OP_PROTECT_CONFIRM)
        |=> status[STS_LOCK_VALID]); // R3

    AST_PROG_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_pwd_n)
        op_active && (op_kind == KIND_PROGRAM)
        |=> !op_active || $stable(op_block)); // R1

    AST_BUSY_DRIVES_LINE: assert property (@(posedge clk) disable iff (!rst_pwd_n)
        op_active |-> ry_by_oe && !ry_by_n); // R9

    AST_BUSY_KEEPS_ERRORS: assert property (@(posedge clk) disable iff (!rst_pwd_n)
        !status[STS_READY] |=> $stable(status[STS_ERS_ERR:STS_PRG_ERR])); // R10

    always @(posedge clk) begin
        if (!rst_pwd_n) begin
            AST_RESET_QUIET: assert (status == 8'h00 && !op_active); // R6
        end
    end

endmodule

bind flash_lock_ctrl flash_lock_chk #(.BLK_W($clog2(NUM_BLOCKS))) u_chk (
    .clk       (clk),
    .rst_pwd_n (rst_pwd_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .status    (status),
    .ry_by_n   (ry_by_n),
    .ry_by_oe  (ry_by_oe),
    .op_active (op_active),
    .op_kind   (op_kind),
    .op_block  (op_block)
);

// File: tb/tb_flash_lock_ctrl.sv
`timescale 1ns/1ps
module tb_flash_lock_ctrl;
    import flash_lock_pkg::*;

    localparam int NB = 32;
    localparam int AW = 19;
    localparam int PC = 4;
    localparam int EC = 6;
    localparam int RC = 10;

    logic          clk = 1'b0;
    logic          por_n, rst_pwd_n, cmd_valid, byte_mode;
    logic [2:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [7:0]    status;
    logic          ry_by_n, ry_by_oe, op_active;
    logic [1:0]    op_kind, op_lanes;
    logic [4:0]    op_block;
    logic [AW-2:0] op_waddr;

    int n_checks = 0;
    int n_fail   = 0;

    int          rb_n;
    logic [31:0] rb_seen;
    bit          rb_order_ok, rb_lanes11, rb_drive_ok, rb_got;
    int          rb_blk, rb_lanes, rb_waddr;
    logic [31:0] lockm;

    flash_lock_ctrl #(
        .ADDR_W(AW), .NUM_BLOCKS(NB), .PROG_CYCLES(PC),
        .ERASE_CYCLES(EC), .RECOV_CYCLES(RC), .LOCK_INIT('0)
    ) dut (
        .clk(clk), .por_n(por_n), .rst_pwd_n(rst_pwd_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .byte_mode(byte_mode),
        .status(status), .ry_by_n(ry_by_n), .ry_by_oe(ry_by_oe),
        .op_active(op_active), .op_kind(op_kind), .op_block(op_block),
        .op_waddr(op_waddr), .op_lanes(op_lanes)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    function automatic logic [AW-1:0] addr_of(input int b, input int low);
        return AW'((b << 14) | (low & 16383));
    endfunction

    // Drive one command strobe; returns at the falling edge after acceptance.
    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic bm);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; byte_mode = bm; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Count busy cycles and record what the array port showed.
    task automatic run_busy();
        int prev = -1;
        rb_n = 0; rb_seen = '0; rb_order_ok = 1; rb_lanes11 = 1; rb_drive_ok = 1; rb_got = 0;
        rb_blk = -1; rb_lanes = -1; rb_waddr = -1;
        while (!status[7] && rb_n < 20000) begin
            if (ry_by_oe !== 1'b1 || ry_by_n !== 1'b0) rb_drive_ok = 0;
            if (op_active) begin
                if (!rb_got) begin
                    rb_got = 1; rb_blk = int'(op_block);
                    rb_lanes = int'(op_lanes); rb_waddr = int'(op_waddr);
                end
                if (!rb_seen[op_block]) begin
                    if (int'(op_block) <= prev) rb_order_ok = 0;
                    prev = int'(op_block);
                    rb_seen[op_block] = 1'b1;
                end
                if (op_lanes != 2'b11) rb_lanes11 = 0;
            end
            @(posedge clk);
            @(negedge clk);
            rb_n++;
        end
    endtask

    task automatic clear_sts();
        issue(OP_CLEAR_STATUS, '0, 1'b0);
    endtask

    initial begin
        #1000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int unl;
        por_n = 1'b0; rst_pwd_n = 1'b0; cmd_valid = 1'b0;
        cmd_op = 3'd0; cmd_addr = '0; byte_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 reset status", int'(status), 0);
        chk("R6 reset op_active", int'(op_active), 0);
        chk("R9 reset drive", int'(ry_by_oe), 1);
        por_n = 1'b1;
        @(negedge clk);
        rst_pwd_n = 1'b1;
        run_busy();
        chk("R7 recovery cycles", rb_n, RC);
        chk("R7 status after recovery", int'(status), 8'h80);
        chk("R9 idle drive", int'({ry_by_oe, ry_by_n}), 1);

        // R2: every section refused before confirmation
        for (int b = 0; b < NB; b++) begin
            issue(OP_PROGRAM, addr_of(b, b * 7), 1'b0);
            chk("R2 program refused", int'({status, op_active}), (8'h90 << 1));
            issue(OP_BLK_ERASE, addr_of(b, 0), 1'b0);
            chk("R2 erase refused", int'(status), 8'hB0);
            clear_sts();
            chk("R12 clear status", int'(status), 8'h80);
        end

        // Lock every third section (R11)
        lockm = '0;
        for (int b = 0; b < NB; b++) begin
            if (b % 3 == 0) begin
                issue(OP_LOCK_BLOCK, addr_of(b, 0), 1'b0);
                lockm[b] = 1'b1;
            end
        end
        unl = 0;
        for (int b = 0; b < NB; b++) if (!lockm[b]) unl++;

        // R4: erase-unlocked before confirmation
        issue(OP_ERASE_UNLOCKED, '0, 1'b0);
        run_busy();
        chk("R4 sweep cycles", rb_n, NB + EC * unl);
        chk("R4 sweep set", int'(rb_seen), int'(~lockm));
        chk("R4 sweep ascending", int'(rb_order_ok), 1);
        chk("R4 sweep lanes", int'(rb_lanes11), 1);
        chk("R9 sweep drive", int'(rb_drive_ok), 1);
        chk("R4 valid after sweep", int'(status), 8'h81);
        issue(OP_PROGRAM, addr_of(1, 0), 1'b0);
        run_busy();
        chk("R4 program after sweep", rb_n, PC);

        // R11: power-down keeps stored bits, clears valid flag
        @(negedge clk); rst_pwd_n = 1'b0;
        @(negedge clk); rst_pwd_n = 1'b1;
        run_busy();
        chk("R6 valid cleared", int'(status), 8'h80);
        issue(OP_PROGRAM, addr_of(1, 0), 1'b0);
        chk("R2 refused after power-down", int'(status), 8'h90);
        clear_sts();
        issue(OP_PROTECT_CONFIRM, '0, 1'b0);
        chk("R3 confirm sets valid", int'(status), 8'h81);

        // R3/R1/R5: sweep every section after confirmation
        for (int b = 0; b < NB; b++) begin
            logic [AW-1:0] a;
            a = addr_of(b, b * 613 + 1);
            issue(OP_PROGRAM, a, 1'b0);
            if (lockm[b]) begin
                chk("R3 locked refused", int'({status, op_active}), (8'h91 << 1));
                clear_sts();
            end else begin
                run_busy();
                chk("R5 program cycles", rb_n, PC);
                chk("R1 section index", rb_blk, b);
                chk("R1 word address", rb_waddr, int'(a >> 1));
                chk("R5 ready after program", int'(status), 8'h81);
            end
        end
        issue(OP_BLK_ERASE, addr_of(2, 0), 1'b0);
        run_busy();
        chk("R5 erase cycles", rb_n, EC);
        issue(OP_BLK_ERASE, addr_of(3, 0), 1'b0);
        chk("R3 erase locked refused", int'(status), 8'hA1);
        clear_sts();

        // R8: lane selection
        for (int bm = 0; bm < 2; bm++) begin
            for (int a0 = 0; a0 < 2; a0++) begin
                issue(OP_PROGRAM, addr_of(1, a0), 1'(bm));
                run_busy();
                chk("R8 lanes", rb_lanes, (bm == 0) ? 3 : ((a0 == 1) ? 2 : 1));
            end
        end

        // R10: commands while busy are ignored
        issue(OP_PROGRAM, addr_of(1, 0), 1'b0);
        issue(OP_UNLOCK_ALL, '0, 1'b0);
        issue(OP_LOCK_BLOCK, addr_of(2, 0), 1'b0);
        run_busy();
        issue(OP_PROGRAM, addr_of(0, 0), 1'b0);
        chk("R10 unlock ignored", int'(status), 8'h91);
        clear_sts();
        issue(OP_PROGRAM, addr_of(2, 0), 1'b0);
        run_busy();
        chk("R10 lock ignored", rb_n, PC);

        // R12: sticky error, clear ignored while busy
        issue(OP_PROGRAM, addr_of(0, 0), 1'b0);
        issue(OP_PROGRAM, addr_of(1, 0), 1'b0);
        issue(OP_CLEAR_STATUS, '0, 1'b0);
        run_busy();
        chk("R12 error sticky", int'(status), 8'h91);
        clear_sts();
        chk("R12 error cleared", int'(status), 8'h81);

        // R11: unlock-all, then power-on reset restores LOCK_INIT
        issue(OP_UNLOCK_ALL, '0, 1'b0);
        issue(OP_PROGRAM, addr_of(0, 0), 1'b0);
        run_busy();
        chk("R11 unlock-all", rb_n, PC);
        issue(OP_LOCK_BLOCK, addr_of(0, 0), 1'b0);
        issue(OP_PROGRAM, addr_of(0, 0), 1'b0);
        chk("R11 lock section", int'(status), 8'h91);
        clear_sts();
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        chk("R11 valid kept over por", int'(status), 8'h81);
        issue(OP_PROGRAM, addr_of(0, 0), 1'b0);
        run_busy();
        chk("R11 por restores init", rb_n, PC);

        // R6: abort mid-erase
        issue(OP_BLK_ERASE, addr_of(3, 0), 1'b0);
        @(negedge clk);
        chk("R5 erase running", int'(op_active), 1);
        rst_pwd_n = 1'b0;
        #1;
        chk("R6 abort op_active", int'(op_active), 0);
        chk("R6 abort status", int'(status), 0);
        chk("R9 abort drive", int'(ry_by_oe), 1);
        @(negedge clk); rst_pwd_n = 1'b1;
        run_busy();
        chk("R7 second recovery", rb_n, RC);
        chk("R6 status after abort", int'(status), 8'h80);

        summary();
    end

endmodule